// File: doc/BRIEF.md
# Boot-Wait Abort Sequencer

After reset this block decides whether a stored program image is started automatically or whether control goes to a human operator. When no valid image is present it passes control to the operator at once. When an image is present it opens a wait window whose length comes from a small stored code. During that window a status LED blinks, and any of three abort sources ends the window early and gives control to the operator: a front-panel pushbutton, an abort strobe from a command interpreter, or a strobe reporting a successful remote login.

If the window runs out with no intervention, the block emits a single-cycle start pulse and settles in a booted state. Both final states stay until the next reset. The length of one second is a parameter in clock cycles, so the same logic can serve any system clock. Wait codes that are not allowed, and any stored settings that failed their integrity check, fall back to a five-second window.

Top module: `boot_wait_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `waiting`, `led`, `op_ctrl`, `booted` and `boot_start` are all low.
- R2: With `image_valid` low when reset is released, `op_ctrl` rises one cycle later with no wait window, no LED activity and no `boot_start`.
- R3: With `image_valid` high and `settings_ok` high, `wait_code` values 0,1,2,3,4,5 give wait windows of 1,2,5,10,20,50 seconds; `waiting` stays high for exactly seconds × `TICKS_PER_SEC` cycles.
- R4: `wait_code` values 6 and 7 are not allowed and give a 5-second window.
- R5: With `settings_ok` low the window is 5 seconds whatever `wait_code` holds.
- R6: `led` is high in the first cycle of the window and toggles every `TICKS_PER_SEC`/4 cycles, giving two flashes (rising edges) per second of the window; it is low whenever `waiting` is low.
- R7: When the window expires with no abort, `boot_start` is high for exactly one cycle, in the same cycle `booted` first goes high.
- R8: A rising edge on the asynchronous `abort_btn` (two-flop synchroniser, then edge detect) during the window raises `op_ctrl` three clock edges after the input rises.
- R9: An `abort_cmd` strobe during the window raises `op_ctrl` on the next cycle.
- R10: A `login_done` strobe with `login_ok` high during the window raises `op_ctrl` on the next cycle; with `login_ok` low it has no effect and the window runs its full length.
- R11: Abort sources that arrive after the window has expired are ignored: `booted` stays high and `op_ctrl` stays low.
- R12: `op_ctrl` and `booted` hold until reset; an abort in the very cycle the window would expire wins, giving `op_ctrl` and no `boot_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| image_valid | input | 1 | A valid program image is stored |
| settings_ok | input | 1 | Stored settings passed their integrity check |
| wait_code | input | 3 | Wait-window code (0..5 allowed) |
| abort_btn | input | 1 | Asynchronous abort pushbutton level |
| abort_cmd | input | 1 | One-cycle abort strobe from the command interpreter |
| login_done | input | 1 | One-cycle strobe at the end of a remote login attempt |
| login_ok | input | 1 | Login result qualifying `login_done` |
| waiting | output | 1 | Wait window is open |
| led | output | 1 | Blinking status LED during the window |
| op_ctrl | output | 1 | Operator has control |
| booted | output | 1 | Image start has been issued |
| boot_start | output | 1 | One-cycle start pulse |

## Verification
A wrong decode of the wait code or a wrong fallback shows as a window length that differs from the expected cycle count, visible only when `waiting` falls, so each code is run to expiry and counted to the cycle. A blink phase counter that is off shows as a wrong number of LED rising edges over the window. A mis-routed abort shows within one to three cycles of the stimulus as `op_ctrl` not rising or `waiting` dropping too early, and a leak out of a final state shows at the next abort stimulus after expiry.

// File: rtl/boot_wait_pkg.sv
package boot_wait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPER = 2'd2,
    ST_BOOT = 2'd3
  } bw_state_e;

  localparam int unsigned FALLBACK_SECS = 5;
  localparam int unsigned LONGEST_SECS  = 50;

  // Allowed window lengths in seconds; anything else falls back.
  function automatic logic [5:0] window_secs(input logic [2:0] code, input logic cfg_ok);
    logic [5:0] s;
    if (!cfg_ok) begin
      s = 6'(FALLBACK_SECS);
    end else begin
      case (code)
        3'd0:    s = 6'd1;
        3'd1:    s = 6'd2;
        3'd2:    s = 6'd5;
        3'd3:    s = 6'd10;
        3'd4:    s = 6'd20;
        3'd5:    s = 6'd50;
        default: s = 6'(FALLBACK_SECS);
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/bw_btn_sync.sv
module bw_btn_sync (
  input  logic clk,
  input  logic rst,
  input  logic btn_async,
  output logic btn_rise
);
  logic s1, s2, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s1     <= btn_async;
      s2     <= s1;
      s_prev <= s2;
    end
  end

  assign btn_rise = s2 & ~s_prev;

  // R8: an edge pulse never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    btn_rise |=> !btn_rise);

endmodule

// File: rtl/bw_wait_timer.sv
module bw_wait_timer #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] code,
  input  logic       cfg_ok,
  output logic       expire
);
  import boot_wait_pkg::*;

  localparam longint unsigned MAX_TICKS = longint'(LONGEST_SECS) * longint'(TICKS_PER_SEC);
  localparam int TW = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] total;

  assign total  = TW'(window_secs(code, cfg_ok)) * TW'(TICKS_PER_SEC);
  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= total - TW'(1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  // R3: the window counts down by one each running cycle
  a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt != '0) |=> cnt == $past(cnt) - TW'(1));

  // R5: bad settings load the five-second window
  a_r5_fallback_load: assert property (@(posedge clk) disable iff (rst)
    (load && !cfg_ok) |=> cnt == TW'(FALLBACK_SECS * TICKS_PER_SEC - 1));

endmodule

// File: rtl/bw_blink.sv
module bw_blink #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic led
);
  localparam int unsigned QUARTER = TICKS_PER_SEC / 4;
  localparam int PW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  logic [PW-1:0] ph;
  logic          tog;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ph  <= '0;
      tog <= 1'b1;
    end else if (ph == PW'(QUARTER - 1)) begin
      ph  <= '0;
      tog <= ~tog;
    end else begin
      ph <= ph + PW'(1);
    end
  end

  assign led = active & tog;

  // R6: phase counter stays within one quarter second
  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph <= PW'(QUARTER - 1));

  // R6: the LED changes level at each quarter-second boundary
  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    (active && ph == PW'(QUARTER - 1)) |=> (!active || led != $past(led)));

endmodule

// File: rtl/boot_wait_seq.sv
module boot_wait_seq #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       image_valid,
  input  logic       settings_ok,
  input  logic [2:0] wait_code,
  input  logic       abort_btn,
  input  logic       abort_cmd,
  input  logic       login_done,
  input  logic       login_ok,
  output logic       waiting,
  output logic       led,
  output logic       op_ctrl,
  output logic       booted,
  output logic       boot_start
);
  import boot_wait_pkg::*;

  bw_state_e state, state_nx;
  logic      btn_rise;
  logic      expire;
  logic      abort_any;
  logic      load;

  bw_btn_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .btn_async (abort_btn),
    .btn_rise  (btn_rise)
  );

  assign abort_any = btn_rise | abort_cmd | (login_done & login_ok);
  assign load      = (state == ST_IDLE) & image_valid;

  bw_wait_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .run    (waiting),
    .code   (wait_code),
    .cfg_ok (settings_ok),
    .expire (expire)
  );

  bw_blink #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_blink (
    .clk    (clk),
    .rst    (rst),
    .active (waiting),
    .led    (led)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: state_nx = image_valid ? ST_WAIT : ST_OPER;
      ST_WAIT: begin
        if (abort_any)   state_nx = ST_OPER;
        else if (expire) state_nx = ST_BOOT;
      end
      default: state_nx = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      boot_start <= 1'b0;
    end else begin
      state      <= state_nx;
      boot_start <= (state == ST_WAIT) && (state_nx == ST_BOOT);
    end
  end

  assign waiting = (state == ST_WAIT);
  assign op_ctrl = (state == ST_OPER);
  assign booted  = (state == ST_BOOT);

  // R2: no image skips the window
  a_r2_skip: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !image_valid) |=> op_ctrl);

  // R7: start pulse is a single cycle and only follows the window
  a_r7_pulse_once: assert property (@(posedge clk) disable iff (rst)
    boot_start |=> !boot_start);
  a_r7_pulse_after_wait: assert property (@(posedge clk) disable iff (rst)
    boot_start |-> (booted && $past(waiting)));

  // R9: command abort during the window hands over control
  a_r9_cmd_abort: assert property (@(posedge clk) disable iff (rst)
    (waiting && abort_cmd) |=> op_ctrl);

  // R10: a failed login alone leaves the window open
  a_r10_fail_login: assert property (@(posedge clk) disable iff (rst)
    (waiting && login_done && !login_ok && !abort_cmd && !btn_rise && !expire) |=> waiting);

  // R12: final states hold
  a_r12_oper_hold: assert property (@(posedge clk) disable iff (rst)
    op_ctrl |=> op_ctrl);
  a_r12_boot_hold: assert property (@(posedge clk) disable iff (rst)
    booted |=> (booted && !op_ctrl));

endmodule

// File: tb/boot_wait_seq_tb.sv
module boot_wait_seq_tb;
  localparam int TPS = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       image_valid = 1'b0;
  logic       settings_ok = 1'b1;
  logic [2:0] wait_code = 3'd0;
  logic       abort_btn = 1'b0;
  logic       abort_cmd = 1'b0;
  logic       login_done = 1'b0;
  logic       login_ok = 1'b0;
  logic       waiting, led, op_ctrl, booted, boot_start;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  boot_wait_seq #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst(rst), .image_valid(image_valid), .settings_ok(settings_ok),
    .wait_code(wait_code), .abort_btn(abort_btn), .abort_cmd(abort_cmd),
    .login_done(login_done), .login_ok(login_ok), .waiting(waiting), .led(led),
    .op_ctrl(op_ctrl), .booted(booted), .boot_start(boot_start)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic img, input logic ok, input logic [2:0] code);
    rst = 1'b1;
    image_valid = img; settings_ok = ok; wait_code = code;
    abort_btn = 0; abort_cmd = 0; login_done = 0; login_ok = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Runs an open window to its end; returns its length and flash count.
  task automatic run_out(output int len, output int flashes);
    logic prev = 1'b0;
    len = 0; flashes = 0;
    while (waiting) begin
      len++;
      if (led && !prev) flashes++;
      prev = led;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; image_valid = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset outputs", {waiting, led, op_ctrl, booted, boot_start}, 0);
  endtask

  task automatic t_no_image;
    start(1'b0, 1'b1, 3'd0);
    check("R2 op_ctrl", op_ctrl, 1);
    check("R2 no wait/led/start", {waiting, led, booted, boot_start}, 0);
    repeat (5) @(negedge clk);
    check("R2 held", {op_ctrl, booted}, 2'b10);
  endtask

  task automatic t_window(input logic ok, input logic [2:0] code, input int secs, input string req);
    int len, fl, pulses;
    start(1'b1, ok, code);
    run_out(len, fl);
    check({req, " window length"}, len, secs * TPS);
    check("R6 flash count", fl, 2 * secs);
    check("R6 led dark after", led, 0);
    pulses = boot_start;
    check("R7 booted with pulse", {booted, boot_start, op_ctrl}, 3'b110);
    repeat (4) begin @(negedge clk); pulses += boot_start; end
    check("R7 single pulse", pulses, 1);
  endtask

  task automatic t_button;
    start(1'b1, 1'b1, 3'd1);
    repeat (3) @(negedge clk);
    abort_btn = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 still waiting after 2 edges", waiting, 1);
    @(negedge clk);
    check("R8 op_ctrl after 3 edges", {op_ctrl, waiting, booted}, 3'b100);
    abort_btn = 1'b0;
  endtask

  task automatic t_cmd;
    start(1'b1, 1'b1, 3'd0);
    repeat (2) @(negedge clk);
    abort_cmd = 1'b1;
    @(negedge clk);
    abort_cmd = 1'b0;
    check("R9 op_ctrl", {op_ctrl, waiting, led}, 3'b100);
  endtask

  task automatic t_login;
    int len, fl;
    start(1'b1, 1'b1, 3'd0);
    @(negedge clk);
    login_done = 1'b1; login_ok = 1'b1;
    @(negedge clk);
    login_done = 1'b0; login_ok = 1'b0;
    check("R10 good login", op_ctrl, 1);
    start(1'b1, 1'b1, 3'd1);
    login_done = 1'b1; login_ok = 1'b0;
    @(negedge clk);
    login_done = 1'b0;
    check("R10 bad login keeps waiting", waiting, 1);
    run_out(len, fl);
    check("R10 full window after bad login", len + 1, 2 * TPS);
    check("R10 boot after bad login", {booted, op_ctrl}, 2'b10);
  endtask

  task automatic t_late;
    int len, fl;
    start(1'b1, 1'b1, 3'd0);
    run_out(len, fl);
    @(negedge clk);
    abort_cmd = 1'b1; login_done = 1'b1; login_ok = 1'b1; abort_btn = 1'b1;
    @(negedge clk);
    abort_cmd = 1'b0; login_done = 1'b0; login_ok = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 late aborts ignored", {booted, op_ctrl, boot_start}, 3'b100);
    abort_btn = 1'b0;
  endtask

  task automatic t_tie;
    int n = 0;
    start(1'b1, 1'b1, 3'd0);
    while (n < TPS - 1) begin n++; @(negedge clk); end
    check("R12 last window cycle", waiting, 1);
    abort_cmd = 1'b1;
    @(negedge clk);
    abort_cmd = 1'b0;
    check("R12 abort wins at expiry", {op_ctrl, booted, boot_start}, 3'b100);
    repeat (20) @(negedge clk);
    check("R12 op_ctrl holds", {op_ctrl, booted}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_no_image;
    t_window(1'b1, 3'd0, 1,  "R3 code0");
    t_window(1'b1, 3'd1, 2,  "R3 code1");
    t_window(1'b1, 3'd2, 5,  "R3 code2");
    t_window(1'b1, 3'd3, 10, "R3 code3");
    t_window(1'b1, 3'd4, 20, "R3 code4");
    t_window(1'b1, 3'd5, 50, "R3 code5");
    t_window(1'b1, 3'd6, 5,  "R4 code6");
    t_window(1'b1, 3'd7, 5,  "R4 code7");
    t_window(1'b0, 3'd5, 5,  "R5 bad settings");
    t_window(1'b0, 3'd0, 5,  "R5 bad settings code0");
    t_button;
    t_cmd;
    t_login;
    t_late;
    t_tie;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule